// File: doc/BRIEF.md
# Two-Wire Register Target with Strap-Selected Address

This block lets a two-wire serial bus controller (I2C) read and write a small bank of 8-bit control registers, for example a delay setting and an audio format code. The bus lines are sampled in the system clock domain through a synchronizer. The block never drives SDA high: it only asserts an output enable that pulls the line low, and the pad and the external pull-up make up the wired-AND bus.

The 7-bit target address is a fixed upper nibble, binary 1101 by default, followed by three bits from strap inputs. A write transaction carries the address byte, then a pointer byte, then any number of data bytes. Each data byte lands in the register the pointer selects, and the pointer then advances. A read transaction returns registers one after another, starting at the current pointer, for as long as the controller acknowledges. The usual way to read is a pointer write, then a repeated start, then a read. The register contents are presented in parallel to the surrounding logic.

Top module: `i2c_reg_target`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high; both are seen in any state. A start, including a repeated start in the middle of a byte, begins a fresh address byte and discards any partly received byte. A stop returns the block to idle.
- R2: The address byte is received MSB first. Its upper seven bits are compared with {ADDR_PREFIX, addr_sel[2:0]}, with addr_sel[2] just below the prefix, and bit 0 is the direction (1 = read). On a match the block pulls SDA low, through sda_oe = 1, for the whole acknowledge clock.
- R3: On a non-matching address the block does not acknowledge, leaves every register unchanged and never asserts sda_oe until the next start, whatever bytes follow.
- R4: In a write, the first byte after the address loads the register pointer with its low log2(NUM_REGS) bits. That byte is acknowledged and writes no register.
- R5: Each later write byte is stored in the register the pointer selects and is acknowledged, and then the pointer increments, wrapping from NUM_REGS-1 to 0.
- R6: Data bits are taken on SCL rising and driven MSB first. sda_oe changes only while SCL is low.
- R7: A read returns the register at the pointer, and the pointer increments after each byte sent. The read continues with the next register for as long as the controller acknowledges, wrapping at NUM_REGS.
- R8: A controller NACK after a read byte ends the transfer: SDA is released and stays released until the next start or stop.
- R9: Reset clears all registers and the pointer to 0 and releases SDA.
- R10: A transaction may carry any number of bytes, including more than NUM_REGS, and the pointer keeps wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; bus lines are oversampled in this domain |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| addr_sel | input | 3 | Strap bits forming the low three address bits |
| reg_q | output | NUM_REGS*8 | Register contents, register k at bits [8k+7:8k] |

## Verification
The bench builds the block with NUM_REGS = 4, so a pointer byte of 0x06 shows the truncation to two bits, and a short burst of three or five bytes crosses the wrap in both directions. The strap inputs are changed during the run, which makes the old address a non-match and exercises matching against two different low-bit patterns. SCL high and low phases last eight system clocks each, which leaves room for the synchronizer delay and lets the reference model compare the register outputs during every SCL high phase.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } tgt_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

    localparam int unsigned BYTE_W = 8;

    function automatic logic addr_hit(input logic [7:0] rx, input logic [6:0] own);
        return rx[7:1] == own;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] line_i,
    output logic [WIDTH-1:0] line_q
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], line_i[g]};
        end
        assign line_q[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events
    import i2c_tgt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_s,
    input  logic     sda_s,
    output bus_evt_t evt
);
    logic scl_p;
    logic sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    always_comb begin
        evt.scl_rise = scl_s & ~scl_p;
        evt.scl_fall = ~scl_s & scl_p;
        evt.start    = scl_s & scl_p & sda_p & ~sda_s;
        evt.stop     = scl_s & scl_p & ~sda_p & sda_s;
        evt.sda      = sda_s;
    end
endmodule

// File: rtl/i2c_proto_fsm.sv
module i2c_proto_fsm
    import i2c_tgt_pkg::*;
#(
    parameter int unsigned PTR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic [6:0]        own_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [PTR_W-1:0]  ptr,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output tgt_state_e        state_o
);
    tgt_state_e        st;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              rw;
    logic              first;
    logic              mack;

    assign state_o = st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            rw      <= 1'b0;
            first   <= 1'b0;
            mack    <= 1'b0;
            ptr     <= '0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (evt.start) begin
                st      <= ST_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (evt.stop) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (st)
                    ST_ADDR: begin
                        if (evt.scl_rise && bit_cnt != 4'd8) begin
                            shreg   <= {shreg[6:0], evt.sda};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (evt.scl_fall && bit_cnt == 4'd8) begin
                            if (addr_hit(shreg, own_addr)) begin
                                st     <= ST_ADDR_ACK;
                                sda_oe <= 1'b1;
                                rw     <= shreg[0];
                            end else begin
                                st <= ST_IGNORE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (evt.scl_fall) begin
                            bit_cnt <= '0;
                            if (rw) begin
                                st     <= ST_RD_BYTE;
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                            end else begin
                                st     <= ST_WR_BYTE;
                                sda_oe <= 1'b0;
                                first  <= 1'b1;
                            end
                        end
                    end
                    ST_WR_BYTE: begin
                        if (evt.scl_rise && bit_cnt != 4'd8) begin
                            shreg   <= {shreg[6:0], evt.sda};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (evt.scl_fall && bit_cnt == 4'd8) begin
                            st     <= ST_WR_ACK;
                            sda_oe <= 1'b1;
                            first  <= 1'b0;
                            if (first) begin
                                ptr <= shreg[PTR_W-1:0];
                            end else begin
                                wr_en   <= 1'b1;
                                wr_idx  <= ptr;
                                wr_data <= shreg;
                                ptr     <= ptr + 1'b1;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (evt.scl_fall) begin
                            st      <= ST_WR_BYTE;
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                        end
                    end
                    ST_RD_BYTE: begin
                        if (evt.scl_fall) begin
                            if (bit_cnt == 4'd7) begin
                                st     <= ST_RD_ACK;
                                sda_oe <= 1'b0;
                                ptr    <= ptr + 1'b1;
                            end else begin
                                bit_cnt <= bit_cnt + 4'd1;
                                shreg   <= {shreg[6:0], 1'b0};
                                sda_oe  <= ~shreg[6];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (evt.scl_rise) begin
                            mack <= ~evt.sda;
                        end else if (evt.scl_fall) begin
                            if (mack) begin
                                st      <= ST_RD_BYTE;
                                bit_cnt <= '0;
                                shreg   <= rd_data;
                                sda_oe  <= ~rd_data[7];
                            end else begin
                                st <= ST_IGNORE;
                            end
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
    import i2c_tgt_pkg::*;
#(
    parameter int unsigned NUM_REGS = 4,
    parameter int unsigned PTR_W    = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [PTR_W-1:0]           wr_idx,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic [PTR_W-1:0]           rd_idx,
    output logic [BYTE_W-1:0]          rd_data,
    output logic [NUM_REGS*BYTE_W-1:0] flat_q
);
    logic [BYTE_W-1:0] mem [NUM_REGS];

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)                                  mem[k] <= '0;
            else if (wr_en && wr_idx == PTR_W'(k))   mem[k] <= wr_data;
        end
        assign flat_q[k*BYTE_W +: BYTE_W] = mem[k];
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter int unsigned NUM_REGS    = 4,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [3:0]  ADDR_PREFIX = 4'b1101
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_oe,
    input  logic [2:0]                 addr_sel,
    output logic [NUM_REGS*BYTE_W-1:0] reg_q
);
    localparam int unsigned PTR_W = (NUM_REGS > 2) ? $clog2(NUM_REGS) : 1;

    logic [1:0]        lines_q;
    logic              scl_sync;
    logic              sda_sync;
    bus_evt_t          evt;
    logic [PTR_W-1:0]  ptr;
    logic              wr_en;
    logic [PTR_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] rd_data;
    tgt_state_e        fsm_state;

    i2c_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .line_i ({sda_i, scl_i}),
        .line_q (lines_q)
    );

    assign scl_sync = lines_q[0];
    assign sda_sync = lines_q[1];

    i2c_bus_events u_evt (
        .clk   (clk),
        .rst   (rst),
        .scl_s (scl_sync),
        .sda_s (sda_sync),
        .evt   (evt)
    );

    i2c_proto_fsm #(.PTR_W(PTR_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .own_addr ({ADDR_PREFIX, addr_sel}),
        .rd_data  (rd_data),
        .ptr      (ptr),
        .sda_oe   (sda_oe),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .state_o  (fsm_state)
    );

    i2c_reg_bank #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (ptr),
        .rd_data (rd_data),
        .flat_q  (reg_q)
    );
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk
    import i2c_tgt_pkg::*;
#(
    parameter int unsigned PTR_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             scl_s,
    input logic             sda_oe,
    input tgt_state_e       state,
    input logic             wr_en,
    input logic [PTR_W-1:0] wr_idx,
    input logic [PTR_W-1:0] ptr
);
    // R6
    oe_stable_scl_high_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe));

    // R2
    addr_ack_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ADDR_ACK) |-> sda_oe);

    // R3
    ignore_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE) |-> !sda_oe);

    // R8
    master_ack_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD_ACK) |-> !sda_oe);

    // R5
    ptr_advance_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (ptr == PTR_W'(wr_idx + 1'b1)));

    // R9
    reset_release_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sda_oe && ptr == '0));
endmodule

bind i2c_reg_target i2c_reg_target_chk #(.PTR_W(PTR_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .scl_s  (scl_sync),
    .sda_oe (sda_oe),
    .state  (fsm_state),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .ptr    (ptr)
);

// File: tb/test_i2c_reg_target.sv
module test_i2c_reg_target;
    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 4;
    localparam int HALF       = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              m_scl = 1'b1;
    logic              m_sda = 1'b1;
    logic [2:0]        addr_sel = 3'b101;
    logic              sda_oe;
    logic [NREG*8-1:0] reg_q;
    wire               sda_bus = m_sda & ~sda_oe;

    int errors = 0;
    int checks = 0;
    int hi_cnt = 0;
    bit quiet  = 1'b0;
    int mreg [NREG];
    int mptr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_reg_target #(.NUM_REGS(NREG)) i_i2c_reg_target (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (m_scl),
        .sda_i    (sda_bus),
        .sda_oe   (sda_oe),
        .addr_sel (addr_sel),
        .reg_q    (reg_q)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [NREG*8-1:0] model_flat();
        logic [NREG*8-1:0] v;
        for (int k = 0; k < NREG; k++) v[k*8 +: 8] = 8'(mreg[k]);
        return v;
    endfunction

    always @(posedge clk) hi_cnt <= m_scl ? hi_cnt + 1 : 0;

    // registers compared with the model in every settled SCL high clock (R4 R5 R3)
    always @(negedge clk) begin
        if (!rst && m_scl && hi_cnt >= 5)
            check(reg_q == model_flat(), "R5 register contents", int'(reg_q), int'(model_flat()));
        if (!rst && quiet)
            check(sda_oe == 1'b0, "R3/R8 SDA released", int'(sda_oe), 0);
    end

    task automatic wait_half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_half();
        m_scl = 1'b1; wait_half();
        m_sda = 1'b0; wait_half();
        m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_half();
        m_scl = 1'b1; wait_half();
        m_sda = 1'b1; wait_half();
    endtask

    task automatic send_bit(input bit b);
        m_sda = b; wait_half();
        m_scl = 1'b1; wait_half();
        m_scl = 1'b0;
    endtask

    // kind: 0 address, 1 pointer, 2 data, 3 ignored
    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input int kind, input string req);
        bit ack;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        if (kind == 1) mptr = int'(b) % NREG;
        if (kind == 2) begin
            mreg[mptr] = int'(b);
            mptr = (mptr + 1) % NREG;
        end
        m_sda = 1'b1; wait_half();
        m_scl = 1'b1;
        repeat (HALF/2) @(negedge clk);
        ack = ~sda_bus;
        check(ack == exp_ack, req, int'(ack), int'(exp_ack));
        repeat (HALF - HALF/2) @(negedge clk);
        m_scl = 1'b0;
    endtask

    task automatic read_byte(input bit give_ack, input string req);
        logic [7:0] got;
        int exp;
        exp = mreg[mptr];
        got = '0;
        m_sda = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wait_half();
            m_scl = 1'b1;
            repeat (HALF/2) @(negedge clk);
            got = {got[6:0], sda_bus};
            repeat (HALF - HALF/2) @(negedge clk);
            m_scl = 1'b0;
        end
        check(got == 8'(exp), req, int'(got), exp);
        mptr = (mptr + 1) % NREG;
        send_bit(~give_ack);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < NREG; k++) mreg[k] = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        // R9 reset state
        check(reg_q == '0, "R9 registers after reset", int'(reg_q), 0);
        check(sda_oe == 1'b0, "R9 SDA released after reset", int'(sda_oe), 0);

        // R9 pointer at 0: read from reset pointer, address 1101101 read
        bus_start();
        send_byte(8'hDB, 1'b1, 0, "R2 ack own address read");
        read_byte(1'b1, "R9 read from pointer 0");
        read_byte(1'b0, "R7 second byte");
        bus_stop();

        // R4 pointer 0x06 -> 2, R5 writes with wrap, R10 burst
        bus_start();
        send_byte(8'hDA, 1'b1, 0, "R2 ack own address write");
        send_byte(8'h06, 1'b1, 1, "R4 pointer byte ack");
        send_byte(8'hA5, 1'b1, 2, "R5 data ack");
        send_byte(8'h3C, 1'b1, 2, "R5 data ack");
        send_byte(8'h81, 1'b1, 2, "R5 data ack after wrap");
        bus_stop();

        // R7 R10: read burst longer than the bank
        bus_start();
        send_byte(8'hDB, 1'b1, 0, "R2 ack read");
        for (int i = 0; i < 4; i++) read_byte(1'b1, "R7 R10 burst read");
        read_byte(1'b0, "R7 burst read last");
        bus_stop();

        // R1 repeated start, R8 NACK releases SDA
        bus_start();
        send_byte(8'hDA, 1'b1, 0, "R2 ack write");
        send_byte(8'h03, 1'b1, 1, "R4 pointer 3");
        bus_start();
        send_byte(8'hDB, 1'b1, 0, "R1 ack after repeated start");
        read_byte(1'b1, "R1 read after repeated start");
        read_byte(1'b0, "R7 wrapped read");
        quiet = 1'b1;
        for (int i = 0; i < 9; i++) send_bit(1'b0);
        check(sda_oe == 1'b0, "R8 SDA released after NACK", int'(sda_oe), 0);
        bus_stop();
        quiet = 1'b0;

        // R3 non-matching address, then bytes that look like the own address
        bus_start();
        quiet = 1'b1;
        send_byte(8'hD8, 1'b0, 3, "R3 no ack for foreign address");
        send_byte(8'hDA, 1'b0, 3, "R3 bytes ignored");
        send_byte(8'h00, 1'b0, 3, "R3 bytes ignored");
        send_byte(8'hFF, 1'b0, 3, "R3 bytes ignored");
        bus_stop();
        quiet = 1'b0;

        // R2 new strap value: old address rejected, new accepted
        addr_sel = 3'b010;
        repeat (4) @(negedge clk);
        bus_start();
        quiet = 1'b1;
        send_byte(8'hDA, 1'b0, 3, "R2 old address rejected");
        bus_stop();
        quiet = 1'b0;
        bus_start();
        send_byte(8'hD4, 1'b1, 0, "R2 ack new address");
        send_byte(8'h01, 1'b1, 1, "R4 pointer 1");
        send_byte(8'h5E, 1'b1, 2, "R5 write reg1");
        send_byte(8'h77, 1'b1, 2, "R5 write reg2");
        bus_start();
        send_byte(8'hD4, 1'b1, 0, "R2 ack");
        send_byte(8'h01, 1'b1, 1, "R4 pointer 1 again");
        bus_start();
        send_byte(8'hD5, 1'b1, 0, "R2 ack read");
        read_byte(1'b1, "R6 MSB first reg1");
        read_byte(1'b0, "R6 MSB first reg2");
        bus_stop();

        // R1 stop after pointer, new transaction reads from it
        bus_start();
        send_byte(8'hD4, 1'b1, 0, "R2 ack");
        send_byte(8'h00, 1'b1, 1, "R4 pointer 0");
        bus_stop();
        bus_start();
        send_byte(8'hD5, 1'b1, 0, "R1 ack after stop");
        read_byte(1'b0, "R1 read reg0 after stop");
        bus_stop();

        // R1 repeated start in mid byte discards partial data
        bus_start();
        send_byte(8'hD4, 1'b1, 0, "R2 ack");
        send_byte(8'h02, 1'b1, 1, "R4 pointer 2");
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_start();
        send_byte(8'hD5, 1'b1, 0, "R1 ack after mid-byte start");
        read_byte(1'b0, "R1 partial byte discarded");
        bus_stop();

        repeat (8) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule